// File: doc/BRIEF.md
# Fetch Address Access Checker

A single registered stage placed ahead of the instruction-fetch and data ports of a processor's memory path. Each request presents a 32-bit address, a port select, a low-order alignment mask and a RAM-mode enable. One clock later the stage returns the address with the masked bits cleared, together with four flags: misalignment, access error, access exception and cache bypass.

Faults come from fixed windows near the top of the address map. Access errors and access exceptions are raised only for instruction fetches. One exception window is lifted when RAM mode is on. The uncacheable windows partly depend on the port. When RAM mode is on, every access is treated as on-chip RAM and skips the cache. At most one fault flag is raised per request. An access error wins over an access exception, and either one wins over a misalignment. Window decoding always uses the corrected address.

Top module: `fetch_addr_checker`

## Requirements
- R1: When `req_addr[MASK_W-1:0] & req_align_mask` is nonzero, the stage flags misalignment, unless R5 suppresses the flag. `rsp_addr` is always `req_addr` with the bits selected by `req_align_mask` cleared.
- R2: An instruction fetch (`req_is_data`=0) whose corrected address lies in 0xFEFF0600–0xFEFF7FFF or in 0xFE800000–0xFEFEFFFF raises `rsp_acc_error`.
- R3: An instruction fetch whose corrected address lies in 0xFE004000–0xFE7FFFFF raises `rsp_acc_except`.
- R4: An instruction fetch in 0xFE000000–0xFE003FFF raises `rsp_acc_except` only while `ram_mode_en`=0.
- R5: At most one of the three fault flags is set. The priority is access error, then access exception, then misalignment.
- R6: A data access (`req_is_data`=1) never raises `rsp_acc_error` or `rsp_acc_except`.
- R7: A corrected address at or above 0xFF000000, or inside 0xFEFF0000–0xFEFFFFFF, always sets `rsp_bypass`.
- R8: `rsp_bypass` is also set for 0xFE000000–0xFE003FFF on the instruction port and for 0xFE400000–0xFE403FFF on the data port.
- R9: While `ram_mode_en`=1, every access sets `rsp_bypass`.
- R10: `rsp_valid` equals `req_valid` delayed by exactly one clock. When `req_valid` is low, the address and flag outputs keep their previous values.
- R11: After reset, `rsp_valid` and all flags are 0 and `rsp_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_is_data | input | 1 | 0 = instruction port, 1 = data port |
| req_align_mask | input | MASK_W | Low address bits that must be zero |
| ram_mode_en | input | 1 | On-chip RAM mode enable |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | 32 | Corrected address |
| rsp_align_fault | output | 1 | Misalignment flag |
| rsp_acc_error | output | 1 | Access error flag |
| rsp_acc_except | output | 1 | Access exception flag |
| rsp_bypass | output | 1 | Access must skip the cache |

## Verification
The assertions check these properties on every cycle:
- the one-cycle timing of the valid strobe;
- that at most one fault flag is raised;
- that returned addresses are aligned;
- that the data port is free of faults;
- that an access error lies inside an error window;
- that the high region and RAM mode force a bypass.

Some behaviour only the bench's scenarios can show. This covers the exact window edges and the RAM-mode lifting of the low exception window. It also covers the port-dependent bypass windows, and the priority when an address is both misaligned and inside a fault window. The bench sweeps boundary addresses under every port, mask and RAM-mode combination, with idle cycles in between to show that the outputs hold.

// File: rtl/fac_pkg.sv
package fac_pkg;
  localparam int unsigned AW = 32;

  typedef enum logic {PORT_INSN = 1'b0, PORT_DATA = 1'b1} port_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          align_fault;
    logic          acc_error;
    logic          acc_except;
    logic          bypass;
  } result_t;

  // instruction-fetch error windows
  localparam int unsigned N_ERR_WIN = 2;
  localparam logic [AW-1:0] ERR_LO [N_ERR_WIN] = '{32'hFEFF_0600, 32'hFE80_0000};
  localparam logic [AW-1:0] ERR_HI [N_ERR_WIN] = '{32'hFEFF_7FFF, 32'hFEFE_FFFF};

  // unconditional instruction exception window
  localparam logic [AW-1:0] EXC_LO      = 32'hFE00_4000;
  localparam logic [AW-1:0] EXC_HI      = 32'hFE7F_FFFF;
  // RAM-gated window (also instruction-port uncacheable window)
  localparam logic [AW-1:0] LOWRAM_LO   = 32'hFE00_0000;
  localparam logic [AW-1:0] LOWRAM_HI   = 32'hFE00_3FFF;
  // data-port uncacheable window
  localparam logic [AW-1:0] DRAM_LO     = 32'hFE40_0000;
  localparam logic [AW-1:0] DRAM_HI     = 32'hFE40_3FFF;
  // always uncacheable
  localparam logic [AW-1:0] IO_LO       = 32'hFEFF_0000;
  localparam logic [AW-1:0] IO_HI       = 32'hFEFF_FFFF;
  localparam logic [AW-1:0] HIGH_BASE   = 32'hFF00_0000;

  function automatic logic in_win(input logic [AW-1:0] a,
                                  input logic [AW-1:0] lo,
                                  input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/fac_rst_sync.sv
module fac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fac_align.sv
module fac_align
  import fac_pkg::*;
#(
  parameter int unsigned MASK_W = 4
) (
  input  logic [AW-1:0]     addr_in,
  input  logic [MASK_W-1:0] mask,
  output logic [AW-1:0]     addr_out,
  output logic              misaligned
);
  localparam int unsigned UPPER_W = AW - MASK_W;

  always_comb begin
    misaligned = |(addr_in[MASK_W-1:0] & mask);
    addr_out   = {addr_in[AW-1:MASK_W], addr_in[MASK_W-1:0] & ~mask};
  end

  logic [UPPER_W-1:0] unused_upper;
  assign unused_upper = addr_in[AW-1:MASK_W];
endmodule

// File: rtl/fac_fault.sv
module fac_fault
  import fac_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          is_data,
  input  logic          ram_en,
  input  logic          misaligned,
  output logic          align_fault,
  output logic          acc_error,
  output logic          acc_except
);
  logic [N_ERR_WIN-1:0] err_hit;

  for (genvar w = 0; w < N_ERR_WIN; w++) begin : g_err
    assign err_hit[w] = in_win(addr, ERR_LO[w], ERR_HI[w]);
  end

  logic exc_hit;
  logic fetch;

  always_comb begin
    fetch       = (port_e'(is_data) == PORT_INSN);
    exc_hit     = in_win(addr, EXC_LO, EXC_HI) ||
                  (!ram_en && in_win(addr, LOWRAM_LO, LOWRAM_HI));
    acc_error   = fetch && (|err_hit);
    acc_except  = fetch && !acc_error && exc_hit;
    align_fault = misaligned && !acc_error && !acc_except;
  end
endmodule

// File: rtl/fac_cache.sv
module fac_cache
  import fac_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          is_data,
  input  logic          ram_en,
  output logic          bypass
);
  logic fixed_nc;
  logic port_nc;

  always_comb begin
    fixed_nc = (addr >= HIGH_BASE) || in_win(addr, IO_LO, IO_HI);
    if (port_e'(is_data) == PORT_DATA) port_nc = in_win(addr, DRAM_LO, DRAM_HI);
    else                               port_nc = in_win(addr, LOWRAM_LO, LOWRAM_HI);
    bypass   = fixed_nc || port_nc || ram_en;
  end
endmodule

// File: rtl/fetch_addr_checker.sv
module fetch_addr_checker
  import fac_pkg::*;
#(
  parameter int unsigned MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_is_data,
  input  logic [MASK_W-1:0] req_align_mask,
  input  logic              ram_mode_en,
  output logic              rsp_valid,
  output logic [31:0]       rsp_addr,
  output logic              rsp_align_fault,
  output logic              rsp_acc_error,
  output logic              rsp_acc_except,
  output logic              rsp_bypass
);
  logic rst_sync_n;

  fac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  logic [AW-1:0] corr_addr;
  logic          misaligned;
  result_t       cur_res;

  fac_align #(.MASK_W(MASK_W)) u_align (
    .addr_in(req_addr), .mask(req_align_mask),
    .addr_out(corr_addr), .misaligned(misaligned)
  );

  fac_fault u_fault (
    .addr(corr_addr), .is_data(req_is_data), .ram_en(ram_mode_en),
    .misaligned(misaligned), .align_fault(cur_res.align_fault),
    .acc_error(cur_res.acc_error), .acc_except(cur_res.acc_except)
  );

  fac_cache u_cache (
    .addr(corr_addr), .is_data(req_is_data), .ram_en(ram_mode_en),
    .bypass(cur_res.bypass)
  );

  assign cur_res.addr = corr_addr;

  // next-state
  logic    valid_q, valid_d;
  result_t res_q, res_d;
  logic    res_en;

  always_comb begin
    valid_d = req_valid;
    res_en  = req_valid;
    res_d   = res_en ? cur_res : res_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
    end
  end

  assign rsp_valid       = valid_q;
  assign rsp_addr        = res_q.addr;
  assign rsp_align_fault = res_q.align_fault;
  assign rsp_acc_error   = res_q.acc_error;
  assign rsp_acc_except  = res_q.acc_except;
  assign rsp_bypass      = res_q.bypass;
endmodule

// File: rtl/fac_checker.sv
module fac_checker
  import fac_pkg::*;
#(
  parameter int unsigned MASK_W = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic              req_is_data,
  input logic [MASK_W-1:0] req_align_mask,
  input logic              ram_mode_en,
  input logic              rsp_valid,
  input logic [31:0]       rsp_addr,
  input logic              rsp_align_fault,
  input logic              rsp_acc_error,
  input logic              rsp_acc_except,
  input logic              rsp_bypass
);
  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  assert_idle_follow_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);
  assert_one_fault_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({rsp_align_fault, rsp_acc_error, rsp_acc_except}));
  assert_aligned_out_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> ((rsp_addr[MASK_W-1:0] & $past(req_align_mask)) == '0));
  assert_data_no_fault_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_is_data) |=> (!rsp_acc_error && !rsp_acc_except));
  assert_error_window_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_acc_error) |->
      (in_win(rsp_addr, ERR_LO[0], ERR_HI[0]) || in_win(rsp_addr, ERR_LO[1], ERR_HI[1])));
  assert_high_bypass_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_addr >= HIGH_BASE) |-> rsp_bypass);
  assert_ram_bypass_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && ram_mode_en) |=> rsp_bypass);
endmodule

bind fetch_addr_checker fac_checker #(.MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .req_valid(req_valid),
  .req_is_data(req_is_data), .req_align_mask(req_align_mask),
  .ram_mode_en(ram_mode_en), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
  .rsp_align_fault(rsp_align_fault), .rsp_acc_error(rsp_acc_error),
  .rsp_acc_except(rsp_acc_except), .rsp_bypass(rsp_bypass)
);

// File: tb/sim_fetch_addr_checker.sv
`timescale 1ns/1ps
module sim_fetch_addr_checker;
  localparam int MW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_is_data, ram_mode_en;
  logic [31:0] req_addr;
  logic [MW-1:0] req_align_mask;
  logic rsp_valid, rsp_align_fault, rsp_acc_error, rsp_acc_except, rsp_bypass;
  logic [31:0] rsp_addr;

  always #2.5 clk = ~clk;

  fetch_addr_checker #(.MASK_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_data(req_is_data), .req_align_mask(req_align_mask),
    .ram_mode_en(ram_mode_en), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_align_fault(rsp_align_fault), .rsp_acc_error(rsp_acc_error),
    .rsp_acc_except(rsp_acc_except), .rsp_bypass(rsp_bypass)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // expected state
  bit          e_valid = 0;
  logic [31:0] e_addr  = '0;
  bit          e_al = 0, e_err = 0, e_exc = 0, e_byp = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit win(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    return a >= lo && a <= hi;
  endfunction

  // behavioural reference
  task automatic model(input logic [31:0] a, input bit d, input logic [MW-1:0] m, input bit ram);
    logic [31:0] ca;
    bit mis;
    ca  = a & ~{28'h0, m};
    mis = (a[MW-1:0] & m) != 0;
    e_addr = ca;
    e_err  = !d && (win(ca, 32'hFEFF0600, 32'hFEFF7FFF) || win(ca, 32'hFE800000, 32'hFEFEFFFF));
    e_exc  = !d && !e_err && (win(ca, 32'hFE004000, 32'hFE7FFFFF) ||
                              (!ram && win(ca, 32'hFE000000, 32'hFE003FFF)));
    e_al   = mis && !e_err && !e_exc;
    e_byp  = ca >= 32'hFF000000 || win(ca, 32'hFEFF0000, 32'hFEFFFFFF) ||
             (!d && win(ca, 32'hFE000000, 32'hFE003FFF)) ||
             (d && win(ca, 32'hFE400000, 32'hFE403FFF)) || ram;
  endtask

  task automatic compare_all();
    check("R10", "rsp_valid", {31'b0, rsp_valid}, {31'b0, e_valid});
    check("R1",  "rsp_addr", rsp_addr, e_addr);
    check("R1",  "align_fault", {31'b0, rsp_align_fault}, {31'b0, e_al});
    check("R2",  "acc_error", {31'b0, rsp_acc_error}, {31'b0, e_err});
    check("R3",  "acc_except", {31'b0, rsp_acc_except}, {31'b0, e_exc});
    check("R7",  "bypass", {31'b0, rsp_bypass}, {31'b0, e_byp});
  endtask

  // one cycle: check previous result, drive next request
  task automatic step(input bit v, input logic [31:0] a, input bit d,
                      input logic [MW-1:0] m, input bit ram);
    @(negedge clk);
    compare_all();
    req_valid = v; req_addr = a; req_is_data = d; req_align_mask = m; ram_mode_en = ram;
    e_valid = v;
    if (v) model(a, d, m, ram);
  endtask

  logic [31:0] pts [20] = '{
    32'h0000_0000, 32'hFDFF_FFFF, 32'hFE00_0000, 32'hFE00_3FFF, 32'hFE00_4000,
    32'hFE3F_FFFF, 32'hFE40_0000, 32'hFE40_3FFF, 32'hFE40_4000, 32'hFE7F_FFFF,
    32'hFE80_0000, 32'hFEFE_FFFF, 32'hFEFF_0000, 32'hFEFF_05FF, 32'hFEFF_0600,
    32'hFEFF_7FFF, 32'hFEFF_8000, 32'hFEFF_FFFF, 32'hFF00_0000, 32'hFFFF_FFFF};
  logic [MW-1:0] masks [4] = '{4'h0, 4'h1, 4'h3, 4'hF};

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_addr = '0; req_is_data = 0; req_align_mask = '0; ram_mode_en = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    compare_all();
    rst_n = 1'b1;
    repeat (4) step(0, 32'h0, 0, '0, 0);
    // sweep window edges: ports (R6, R8), RAM mode (R4, R9),
    // masks including misaligned fault addresses (R1, R5)
    for (int p = 0; p < 20; p++)
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < 2; r++)
          for (int k = 0; k < 4; k++) begin
            step(1, pts[p], d[0], masks[k], r[0]);
            if (k == 3) step(0, 32'hDEAD_BEEF, 0, 4'hF, 1); // R10 hold while idle
          end
    // R5: misaligned inside error/exception windows
    step(1, 32'hFEFF_0601, 0, 4'h1, 0);
    step(1, 32'hFE00_4003, 0, 4'h3, 0);
    step(1, 32'hFE00_0001, 0, 4'h1, 1);
    // just below error window after correction
    step(1, 32'hFEFF_05FF, 0, 4'h1, 0);
    // scattered addresses in the upper region
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      a = {8'hFE + 8'($urandom_range(0, 1)), 24'($urandom)};
      step($urandom_range(0, 3) != 0, a, 1'($urandom), MW'($urandom), 1'($urandom));
    end
    step(0, '0, 0, '0, 0);
    step(0, '0, 0, '0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule